// File: doc/BRIEF.md
# GPIO Output Register and Pin Multiplexer

This block holds the output side of an I/O port with up to 32 lines. For every line it keeps an output data bit, an output enable bit, an open-drain (multi-drive) bit, pull-up and pull-down bits, a plain-I/O bit and a two-bit peripheral function select. Each line drives its pad either from its own data and enable bits, or from one of four peripheral functions. A line in open-drain mode never drives high.

Software changes every configuration field through a pair of addresses: one sets the lines written as one, the other clears them. Lines written as zero are left unchanged. A masked write updates many data bits in one access. Only the lines enabled in a separate write-mask register change. A keyed control word turns write protection on or off. While protection is on, configuration writes are dropped and each dropped write raises a sticky violation flag. Reading the status word clears that flag.

Top module: `gpio_outmux`

## Requirements
- R1: After reset, output enable, data, open-drain, pull-up, pull-down, both select registers, the write mask, protection and the violation flag are all zero, and the plain-I/O register is all ones.
- R2: A write to a set address ORs the written ones into its field, and a write to a clear address removes them. Zero bits change nothing. Word addresses (set/clear): enable 0/1, data 2/3, open-drain 4/5, pull-up 6/7, pull-down 8/9, select-low 10/11, select-high 12/13, plain-I/O 14/15, write mask 16/17. A write takes effect at the next clock edge.
- R3: A line with plain-I/O set and open-drain clear drives its data bit on pad_out and its enable bit on pad_oe.
- R4: A line with plain-I/O clear takes pad_out and pad_oe from function f = {select-high, select-low}. The value comes from periph_out[f*NUM_LINES + line] and the enable from periph_oe at the same position.
- R5: On an open-drain line pad_out is 0, and pad_oe equals the selected enable AND the inverse of the selected value. The line never drives a one.
- R6: A pull-up set write clears pull-down on the same lines, and a pull-down set write clears pull-up. No line ever has both pad_pu and pad_pd high.
- R7: A write to address 18 replaces the data bit of each line whose write-mask bit is one. All other data bits keep their values.
- R8: A write to address 19 whose bits [31:8] equal KEY sets protection to bit 0 of the write. With any other key value the write does not change protection.
- R9: While protection is on, writes to addresses 0, 1 and 4 to 17 change nothing. Data writes (2, 3, 18) still take effect.
- R10: A write dropped under R9 sets the violation flag. So does a wrong-key write to address 19 while protection is on. Address 20 reads {viol, prot} in bits [1:0]. A read there with rd_en high clears the flag at the next edge, unless a dropped write happens in the same cycle, in which case the flag stays set.
- R11: rd_data shows, with no delay, the field at each set address (0, 2, 4, …, 16), zero-extended. Other addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write word address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe (clears violation at address 20) |
| rd_addr | input | 5 | Read word address |
| rd_data | output | 32 | Read data |
| periph_out | input | 4*NUM_LINES | Peripheral values, function f at [f*NUM_LINES +: NUM_LINES] |
| periph_oe | input | 4*NUM_LINES | Peripheral enables, same layout |
| pad_out | output | NUM_LINES | Pad output value |
| pad_oe | output | NUM_LINES | Pad output enable |
| pad_pu | output | NUM_LINES | Pull-up enable |
| pad_pd | output | NUM_LINES | Pull-down enable |

## Verification
The flag-clearing status read and a dropped configuration write can land in the same cycle. When they do, the set has to win over the clear. The bench forces this on purpose: with protection on, it issues a blocked open-drain write while it also strobes a read of address 20. It expects that read to return the old flag in the same cycle, and the flag to still read one afterwards. Random traffic also sets rd_en on status reads while random writes hit protected addresses. A reference model decides each cycle whether the flag should end up set or cleared.

// File: rtl/gpio_outmux_pkg.sv
package gpio_outmux_pkg;
    localparam int unsigned BUS_W     = 32;
    localparam int unsigned ADDR_W    = 5;
    localparam int unsigned NUM_FUNCS = 4;
    localparam int unsigned SEL_W     = $clog2(NUM_FUNCS);
    localparam int unsigned KEY_W     = 24;
    localparam logic [KEY_W-1:0] KEY_DEFAULT = 24'h5AC3E1;

    typedef enum logic [ADDR_W-1:0] {
        A_OE_SET  = 5'd0,  A_OE_CLR  = 5'd1,
        A_DAT_SET = 5'd2,  A_DAT_CLR = 5'd3,
        A_MD_SET  = 5'd4,  A_MD_CLR  = 5'd5,
        A_PU_SET  = 5'd6,  A_PU_CLR  = 5'd7,
        A_PD_SET  = 5'd8,  A_PD_CLR  = 5'd9,
        A_SLO_SET = 5'd10, A_SLO_CLR = 5'd11,
        A_SHI_SET = 5'd12, A_SHI_CLR = 5'd13,
        A_IO_SET  = 5'd14, A_IO_CLR  = 5'd15,
        A_MSK_SET = 5'd16, A_MSK_CLR = 5'd17,
        A_SYNC    = 5'd18,
        A_WP_CTRL = 5'd19,
        A_WP_STAT = 5'd20
    } reg_addr_e;
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_outmux_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32,
    parameter logic [KEY_W-1:0] KEY = KEY_DEFAULT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [BUS_W-1:0]     wr_data,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [BUS_W-1:0]     rd_data,
    output logic [NUM_LINES-1:0] oe_q,
    output logic [NUM_LINES-1:0] dat_q,
    output logic [NUM_LINES-1:0] md_q,
    output logic [NUM_LINES-1:0] pu_q,
    output logic [NUM_LINES-1:0] pd_q,
    output logic [NUM_LINES-1:0] slo_q,
    output logic [NUM_LINES-1:0] shi_q,
    output logic [NUM_LINES-1:0] io_q,
    output logic [NUM_LINES-1:0] msk_q,
    output logic                 wp_q,
    output logic                 viol_q
);
    typedef struct packed {
        logic [NUM_LINES-1:0] oe;
        logic [NUM_LINES-1:0] dat;
        logic [NUM_LINES-1:0] md;
        logic [NUM_LINES-1:0] pu;
        logic [NUM_LINES-1:0] pd;
        logic [NUM_LINES-1:0] slo;
        logic [NUM_LINES-1:0] shi;
        logic [NUM_LINES-1:0] io;
        logic [NUM_LINES-1:0] msk;
        logic                 wp;
        logic                 viol;
    } cfg_t;

    cfg_t st_d, st_q;
    logic [NUM_LINES-1:0] lines;
    logic key_ok, cfg_hit, blocked;

    always_comb begin
        st_d    = st_q;
        lines   = wr_data[NUM_LINES-1:0];
        key_ok  = (wr_data[BUS_W-1:BUS_W-KEY_W] == KEY);
        case (wr_addr)
            A_OE_SET, A_OE_CLR, A_MD_SET, A_MD_CLR, A_PU_SET, A_PU_CLR,
            A_PD_SET, A_PD_CLR, A_SLO_SET, A_SLO_CLR, A_SHI_SET, A_SHI_CLR,
            A_IO_SET, A_IO_CLR, A_MSK_SET, A_MSK_CLR: cfg_hit = 1'b1;
            default:                                  cfg_hit = 1'b0;
        endcase
        blocked = wr_en && st_q.wp &&
                  (cfg_hit || (wr_addr == A_WP_CTRL && !key_ok));
        if (rd_en && rd_addr == A_WP_STAT) st_d.viol = 1'b0;
        if (blocked)                       st_d.viol = 1'b1;
        if (wr_en && !blocked) begin
            case (wr_addr)
                A_OE_SET:  st_d.oe  = st_q.oe  |  lines;
                A_OE_CLR:  st_d.oe  = st_q.oe  & ~lines;
                A_DAT_SET: st_d.dat = st_q.dat |  lines;
                A_DAT_CLR: st_d.dat = st_q.dat & ~lines;
                A_MD_SET:  st_d.md  = st_q.md  |  lines;
                A_MD_CLR:  st_d.md  = st_q.md  & ~lines;
                A_PU_SET: begin
                    st_d.pu = st_q.pu |  lines;
                    st_d.pd = st_q.pd & ~lines;
                end
                A_PU_CLR:  st_d.pu  = st_q.pu  & ~lines;
                A_PD_SET: begin
                    st_d.pd = st_q.pd |  lines;
                    st_d.pu = st_q.pu & ~lines;
                end
                A_PD_CLR:  st_d.pd  = st_q.pd  & ~lines;
                A_SLO_SET: st_d.slo = st_q.slo |  lines;
                A_SLO_CLR: st_d.slo = st_q.slo & ~lines;
                A_SHI_SET: st_d.shi = st_q.shi |  lines;
                A_SHI_CLR: st_d.shi = st_q.shi & ~lines;
                A_IO_SET:  st_d.io  = st_q.io  |  lines;
                A_IO_CLR:  st_d.io  = st_q.io  & ~lines;
                A_MSK_SET: st_d.msk = st_q.msk |  lines;
                A_MSK_CLR: st_d.msk = st_q.msk & ~lines;
                A_SYNC:    st_d.dat = (st_q.dat & ~st_q.msk) | (lines & st_q.msk);
                A_WP_CTRL: if (key_ok) st_d.wp = wr_data[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.io <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_OE_SET:  rd_data[NUM_LINES-1:0] = st_q.oe;
            A_DAT_SET: rd_data[NUM_LINES-1:0] = st_q.dat;
            A_MD_SET:  rd_data[NUM_LINES-1:0] = st_q.md;
            A_PU_SET:  rd_data[NUM_LINES-1:0] = st_q.pu;
            A_PD_SET:  rd_data[NUM_LINES-1:0] = st_q.pd;
            A_SLO_SET: rd_data[NUM_LINES-1:0] = st_q.slo;
            A_SHI_SET: rd_data[NUM_LINES-1:0] = st_q.shi;
            A_IO_SET:  rd_data[NUM_LINES-1:0] = st_q.io;
            A_MSK_SET: rd_data[NUM_LINES-1:0] = st_q.msk;
            A_WP_STAT: rd_data[1:0]           = {st_q.viol, st_q.wp};
            default: ;
        endcase
    end

    assign oe_q   = st_q.oe;
    assign dat_q  = st_q.dat;
    assign md_q   = st_q.md;
    assign pu_q   = st_q.pu;
    assign pd_q   = st_q.pd;
    assign slo_q  = st_q.slo;
    assign shi_q  = st_q.shi;
    assign io_q   = st_q.io;
    assign msk_q  = st_q.msk;
    assign wp_q   = st_q.wp;
    assign viol_q = st_q.viol;
endmodule

// File: rtl/gpio_line_mux.sv
module gpio_line_mux
    import gpio_outmux_pkg::*;
(
    input  logic                 io_en,
    input  logic                 md,
    input  logic [SEL_W-1:0]     sel,
    input  logic                 dat,
    input  logic                 oe,
    input  logic [NUM_FUNCS-1:0] fn_out,
    input  logic [NUM_FUNCS-1:0] fn_oe,
    output logic                 pad_out,
    output logic                 pad_oe
);
    logic val, en;

    always_comb begin
        if (io_en) begin
            val = dat;
            en  = oe;
        end else begin
            val = fn_out[sel];
            en  = fn_oe[sel];
        end
        pad_out = md ? 1'b0 : val;
        pad_oe  = md ? (en & ~val) : en;
    end
endmodule

// File: rtl/gpio_outmux.sv
module gpio_outmux
    import gpio_outmux_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32,
    parameter logic [KEY_W-1:0] KEY = KEY_DEFAULT
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [BUS_W-1:0]               wr_data,
    input  logic                           rd_en,
    input  logic [ADDR_W-1:0]              rd_addr,
    output logic [BUS_W-1:0]               rd_data,
    input  logic [NUM_FUNCS*NUM_LINES-1:0] periph_out,
    input  logic [NUM_FUNCS*NUM_LINES-1:0] periph_oe,
    output logic [NUM_LINES-1:0]           pad_out,
    output logic [NUM_LINES-1:0]           pad_oe,
    output logic [NUM_LINES-1:0]           pad_pu,
    output logic [NUM_LINES-1:0]           pad_pd
);
    logic [NUM_LINES-1:0] oe_q, dat_q, md_q, pu_q, pd_q, slo_q, shi_q, io_q, msk_q;
    logic wp_q, viol_q;
    logic [NUM_LINES-1:0][NUM_FUNCS-1:0] fn_out_l, fn_oe_l;

    gpio_cfg_regs #(.NUM_LINES(NUM_LINES), .KEY(KEY)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .oe_q(oe_q), .dat_q(dat_q), .md_q(md_q), .pu_q(pu_q), .pd_q(pd_q),
        .slo_q(slo_q), .shi_q(shi_q), .io_q(io_q), .msk_q(msk_q),
        .wp_q(wp_q), .viol_q(viol_q)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_fn
            assign fn_out_l[i][f] = periph_out[f*NUM_LINES + i];
            assign fn_oe_l[i][f]  = periph_oe[f*NUM_LINES + i];
        end
        gpio_line_mux u_mux (
            .io_en(io_q[i]), .md(md_q[i]), .sel({shi_q[i], slo_q[i]}),
            .dat(dat_q[i]), .oe(oe_q[i]),
            .fn_out(fn_out_l[i]), .fn_oe(fn_oe_l[i]),
            .pad_out(pad_out[i]), .pad_oe(pad_oe[i])
        );
    end

    assign pad_pu = pu_q;
    assign pad_pd = pd_q;
endmodule

// File: rtl/gpio_outmux_chk.sv
module gpio_outmux_chk
    import gpio_outmux_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32,
    parameter logic [KEY_W-1:0] KEY = KEY_DEFAULT
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    wr_addr,
    input logic [BUS_W-1:0]     wr_data,
    input logic [NUM_LINES-1:0] pad_out,
    input logic [NUM_LINES-1:0] pad_oe,
    input logic [NUM_LINES-1:0] pad_pu,
    input logic [NUM_LINES-1:0] pad_pd,
    input logic [NUM_LINES-1:0] oe_q,
    input logic [NUM_LINES-1:0] dat_q,
    input logic [NUM_LINES-1:0] md_q,
    input logic [NUM_LINES-1:0] msk_q,
    input logic                 wp_q,
    input logic                 viol_q
);
    logic [NUM_LINES-1:0] wr_lines;
    assign wr_lines = wr_data[NUM_LINES-1:0];

    // R6
    pull_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_pd) == '0);

    // R5
    od_no_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (md_q & pad_oe & pad_out) == '0);

    // R7
    sync_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_SYNC) |=>
        dat_q == (($past(dat_q) & ~$past(msk_q)) | ($past(wr_lines) & $past(msk_q))));

    // R9
    prot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_q && wr_en && (wr_addr == A_OE_SET || wr_addr == A_OE_CLR)) |=> $stable(oe_q));

    // R10
    viol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_q && wr_en && (wr_addr == A_MD_SET || wr_addr == A_MD_CLR)) |=> viol_q);

    // R8
    bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_WP_CTRL && wr_data[BUS_W-1:BUS_W-KEY_W] != KEY) |=> $stable(wp_q));
endmodule

bind gpio_outmux gpio_outmux_chk #(.NUM_LINES(NUM_LINES), .KEY(KEY)) u_chk (.*);

// File: tb/test_gpio_outmux.sv
`timescale 1ns/100ps
module test_gpio_outmux;
    localparam int N = 32;
    localparam int CLK_PERIOD = 10;
    localparam logic [23:0] KEY = 24'h5AC3E1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [4:0] wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0, rd_data;
    logic [4*N-1:0] periph_out = '0, periph_oe = '0;
    logic [N-1:0] pad_out, pad_oe, pad_pu, pad_pd;

    logic [N-1:0] m_oe, m_dat, m_md, m_pu, m_pd, m_slo, m_shi, m_io, m_msk;
    logic m_wp, m_vi;
    int n_chk = 0, n_fail = 0;
    int cyc = 0;

    gpio_outmux #(.NUM_LINES(N), .KEY(KEY)) i_gpio_outmux (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .periph_out(periph_out), .periph_oe(periph_oe),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd));

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=%0d expected<=200000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [2*N-1:0] exp_pads();
        logic [N-1:0] eo, ee;
        for (int i = 0; i < N; i++) begin
            logic v, e;
            int f;
            f = {m_shi[i], m_slo[i]};
            if (m_io[i]) begin v = m_dat[i]; e = m_oe[i]; end
            else begin v = periph_out[f*N+i]; e = periph_oe[f*N+i]; end
            eo[i] = m_md[i] ? 1'b0 : v;
            ee[i] = m_md[i] ? (e & ~v) : e;
        end
        return {ee, eo};
    endfunction

    task automatic model_update(input logic we, input logic [4:0] wa, input logic [31:0] wd,
                                input logic re, input logic [4:0] ra);
        logic [N-1:0] l;
        logic cfg, blk;
        l   = wd[N-1:0];
        cfg = (wa == 0) || (wa == 1) || (wa >= 4 && wa <= 17);
        blk = we && m_wp && (cfg || (wa == 19 && wd[31:8] != KEY));
        if (re && ra == 20) m_vi = 1'b0;
        if (blk) m_vi = 1'b1;
        if (we && !blk) begin
            case (wa)
                0: m_oe = m_oe | l;    1: m_oe = m_oe & ~l;
                2: m_dat = m_dat | l;  3: m_dat = m_dat & ~l;
                4: m_md = m_md | l;    5: m_md = m_md & ~l;
                6: begin m_pu = m_pu | l; m_pd = m_pd & ~l; end
                7: m_pu = m_pu & ~l;
                8: begin m_pd = m_pd | l; m_pu = m_pu & ~l; end
                9: m_pd = m_pd & ~l;
                10: m_slo = m_slo | l; 11: m_slo = m_slo & ~l;
                12: m_shi = m_shi | l; 13: m_shi = m_shi & ~l;
                14: m_io = m_io | l;   15: m_io = m_io & ~l;
                16: m_msk = m_msk | l; 17: m_msk = m_msk & ~l;
                18: m_dat = (m_dat & ~m_msk) | (l & m_msk);
                19: if (wd[31:8] == KEY) m_wp = wd[0];
                default: ;
            endcase
        end
    endtask

    task automatic compare_all();
        logic [2*N-1:0] ep;
        ep = exp_pads();
        chk("R3/R4/R5 pad_out", pad_out, ep[N-1:0]);
        chk("R3/R4/R5 pad_oe", pad_oe, ep[2*N-1:N]);
        chk("R6 pad_pu", pad_pu, m_pu);
        chk("R6 pad_pd", pad_pd, m_pd);
        chk("R6 pull exclusive", pad_pu & pad_pd, '0);
        rd_addr = 0;  #0.4 chk("R2/R11 oe read", rd_data, m_oe);
        rd_addr = 2;  #0.4 chk("R2/R7 data read", rd_data, m_dat);
        rd_addr = 4;  #0.4 chk("R2/R11 md read", rd_data, m_md);
        rd_addr = 10; #0.4 chk("R2/R11 sel-low read", rd_data, m_slo);
        rd_addr = 12; #0.4 chk("R2/R11 sel-high read", rd_data, m_shi);
        rd_addr = 14; #0.4 chk("R2/R11 io read", rd_data, m_io);
        rd_addr = 16; #0.4 chk("R2/R11 mask read", rd_data, m_msk);
        rd_addr = 21; #0.4 chk("R11 unmapped read", rd_data, 32'h0);
        rd_addr = 20; #0.4 chk("R8/R10 status read", rd_data, {30'b0, m_vi, m_wp});
    endtask

    task automatic step(input logic we, input logic [4:0] wa, input logic [31:0] wd,
                        input logic re, input logic [4:0] ra);
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
        #1;
        if (re && ra == 20) chk("R10 status during clearing read", rd_data, {30'b0, m_vi, m_wp});
        @(posedge clk);
        model_update(we, wa, wd, re, ra);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        compare_all();
    endtask

    initial begin
        void'($urandom(32'd1234));
        m_oe = '0; m_dat = '0; m_md = '0; m_pu = '0; m_pd = '0;
        m_slo = '0; m_shi = '0; m_io = '1; m_msk = '0; m_wp = 1'b0; m_vi = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pad_oe after reset", pad_oe, '0);
        rd_addr = 14; #0.4 chk("R1 io all ones", rd_data, 32'hFFFF_FFFF);
        compare_all();

        // R2/R3 set and clear
        step(1, 0, 32'h0000_FF0F, 0, 0);
        step(1, 2, 32'h0000_0F0F, 0, 0);
        step(1, 1, 32'h0000_000F, 0, 0);
        chk("R3 gpio drive", pad_oe & pad_out, 32'h0000_0F00);
        // R4 peripheral routing: lines 0..7 to function 2
        periph_out = {32'hAAAA_0000, 32'h0000_00F0, 32'h0, 32'h0};
        periph_oe  = {N{4'b0100}} & {4*N{1'b1}};
        periph_oe[2*N +: N] = '1;
        step(1, 12, 32'h0000_00FF, 0, 0);
        step(1, 15, 32'h0000_00FF, 0, 0);
        chk("R4 function 2 value", pad_out[7:0], 32'h0000_00F0);
        // R5 open drain
        step(1, 4, 32'h0000_0FFF, 0, 0);
        chk("R5 no high drive", pad_out[11:0], 32'h0);
        // R6 pull exclusivity
        step(1, 6, 32'h0000_FFFF, 0, 0);
        step(1, 8, 32'h0000_00FF, 0, 0);
        chk("R6 pu cleared by pd set", pad_pu, 32'h0000_FF00);
        // R7 masked all-lines write
        step(1, 16, 32'hF0F0_F0F0, 0, 0);
        step(1, 18, 32'h1234_5678, 0, 0);
        chk("R7 masked data", m_dat, (32'h0000_0F0F & 32'h0F0F_0F0F) | (32'h1234_5678 & 32'hF0F0_F0F0));
        // R8 wrong key then right key
        step(1, 19, {24'h123456, 8'h01}, 0, 0);
        chk("R8 wrong key ignored", m_wp, 1'b0);
        step(1, 19, {KEY, 8'h01}, 0, 0);
        // R9 blocked config, data allowed
        step(1, 0, 32'hFFFF_FFFF, 0, 0);
        step(1, 3, 32'h0000_00FF, 0, 0);
        // R10 blocked write and clearing read together: set wins
        step(1, 4, 32'hFFFF_0000, 1, 20);
        chk("R10 flag kept over clear", m_vi, 1'b1);
        step(0, 0, 32'h0, 1, 20);
        chk("R10 flag cleared by read", m_vi, 1'b0);
        step(1, 19, {24'hBADBAD, 8'h00}, 0, 0);
        step(1, 19, {KEY, 8'h00}, 0, 0);

        for (int k = 0; k < 1500; k++) begin
            logic [4:0] a, ra;
            logic [31:0] d;
            logic re;
            a = 5'($urandom_range(0, 21));
            d = $urandom;
            if (a == 19) d[31:8] = ($urandom_range(0, 3) != 0) ? KEY : 24'($urandom);
            re = ($urandom_range(0, 3) == 0);
            ra = ($urandom_range(0, 1) == 0) ? 5'd20 : 5'($urandom_range(0, 21));
            periph_out = {$urandom, $urandom, $urandom, $urandom};
            periph_oe  = {$urandom, $urandom, $urandom, $urandom};
            step(($urandom_range(0, 7) != 0), a, d, re, ra);
        end

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule